// File: doc/BRIEF.md
# Serial Control Word Loader with Modulator Reset Sequencer

This block takes control words over a three-wire serial port: a serial clock, a data line and a load strobe. All three inputs, together with an external divider output, pass through a synchronizer chain into the system clock domain. The block captures data MSB first on each rising serial clock edge. On a rising strobe edge it checks the two address bits of the 24-bit word. If the address selects the control word, the block updates a set of parallel field registers. These are a 14-bit divider value, a charge-pump ratio, a lock-detect mode, a modulator-reset enable and a comparison select.

A control-word load with the reset enable set arms a reset sequencer for a sigma-delta modulator. The sequencer counts falling edges of the synchronized divider output. The reset output rises on the first such edge after the strobe and falls on the second. If another qualifying load arrives while the sequence is running, the output drops and the count begins again.

Top module: `ctrl_word_loader`

## Requirements
- R1: After reset every field output is zero and mod_rst_o is low.
- R2: Each rising serial clock edge shifts one data bit into a 24-bit register, MSB first. When the strobe rises, only the last 24 bits shifted in are used.
- R3: A strobe rise with word bits [23:22] equal to binary 10 loads the fields from the word. The divider value comes from bits [21:8], cp_ratio_o from [7:6], lock_mode_o from [5:4], mod_rst_en_o from bit 3 and cmp_sel_o from [2:0]. The outputs update on the third clk_i edge after the strobe input rises.
- R4: A strobe rise with any other address leaves every field output unchanged.
- R5: Shifting serial data without a strobe leaves every field output unchanged.
- R6: After a control-word load with bit 3 set, mod_rst_o rises on the first falling edge of div_out_i and falls on the second. Each change appears on the third clk_i edge after div_out_i falls.
- R7: A control-word load with bit 3 clear never asserts mod_rst_o, however many divider edges follow.
- R8: A qualifying load during an active or armed sequence restarts it. mod_rst_o goes low, and then again needs one falling edge to rise and a second to fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial port clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_strobe_i | input | 1 | Load strobe, rising edge latches the word |
| div_out_i | input | 1 | External divider output, asynchronous |
| div_val_o | output | 14 | Divider value field |
| cp_ratio_o | output | 2 | Charge-pump ratio field |
| lock_mode_o | output | 2 | Lock-detect mode field |
| mod_rst_en_o | output | 1 | Modulator-reset enable field |
| cmp_sel_o | output | 3 | Comparison select field |
| mod_rst_o | output | 1 | Modulator reset, high between two divider falling edges |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and address match binary 10. This fixes the input-to-output latency at three clk_i edges, and a delay-line reference model follows it cycle by cycle. With these values the bench can reach overlong serial bursts and loads to a non-matching address. It can also reach a strobe that lands while the modulator reset is high, and divider toggling after a load with the enable clear.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 14;
  localparam int CP_W   = 2;
  localparam int LD_W   = 2;
  localparam int SEL_W  = 3;

  localparam int SEL_LSB  = 0;
  localparam int EN_BIT   = SEL_LSB + SEL_W;
  localparam int LD_LSB   = EN_BIT + 1;
  localparam int CP_LSB   = LD_LSB + LD_W;
  localparam int DIV_LSB  = CP_LSB + CP_W;
  localparam int ADDR_LSB = WORD_W - ADDR_W;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [CP_W-1:0]  cp;
    logic [LD_W-1:0]  ld;
    logic             rst_en;
    logic [SEL_W-1:0] sel;
  } ctrl_fields_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_e;

  function automatic ctrl_fields_t unpack_word(input logic [WORD_W-1:0] w);
    ctrl_fields_t f;
    f.div    = w[DIV_LSB +: DIV_W];
    f.cp     = w[CP_LSB +: CP_W];
    f.ld     = w[LD_LSB +: LD_W];
    f.rst_en = w[EN_BIT];
    f.sel    = w[SEL_LSB +: SEL_W];
    return f;
  endfunction
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) st_q[g] <= '0;
          else         st_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) st_q[g] <= '0;
          else         st_q[g] <= st_q[g-1];
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cwl_shift.sv
module cwl_shift
  import cwl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};

  assign word_o = sr_q;

  // newest bit lands at LSB, older bits move up
  assert_shift_msb_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[0] == $past(bit_i)) && (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])));
endmodule

// File: rtl/cwl_fields.sv
module cwl_fields
  import cwl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output ctrl_fields_t      fields_o
);
  ctrl_fields_t fields_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     fields_q <= '0;
    else if (load_i) fields_q <= unpack_word(word_i);

  assign fields_o = fields_q;

  assert_load_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (fields_q.div == $past(word_i[21:8])) && (fields_q.cp == $past(word_i[7:6]))
               && (fields_q.ld == $past(word_i[5:4])) && (fields_q.rst_en == $past(word_i[3]))
               && (fields_q.sel == $past(word_i[2:0])));

  assert_hold_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(fields_q));
endmodule

// File: rtl/cwl_rst_seq.sv
module cwl_rst_seq
  import cwl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic fall_i,
  output logic mod_rst_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (trig_i) state_d = SEQ_ARMED;   // restart wins over an edge
    else if (fall_i) begin
      unique case (state_q)
        SEQ_ARMED: state_d = SEQ_HOLD;
        SEQ_HOLD:  state_d = SEQ_IDLE;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;

  assign mod_rst_o = (state_q == SEQ_HOLD);

  assert_rst_rise_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_o) |-> $past(fall_i) && !$past(trig_i));

  assert_rst_fall_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_rst_o) |-> $past(fall_i) || $past(trig_i));

  assert_restart_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !mod_rst_o);
endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
  import cwl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_MATCH = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_strobe_i,
  input  logic              div_out_i,
  output logic [DIV_W-1:0]  div_val_o,
  output logic [CP_W-1:0]   cp_ratio_o,
  output logic [LD_W-1:0]   lock_mode_o,
  output logic              mod_rst_en_o,
  output logic [SEL_W-1:0]  cmp_sel_o,
  output logic              mod_rst_o
);
  localparam int NIN = 4;
  localparam int I_SCK = 0, I_SDA = 1, I_STB = 2, I_DIV = 3;

  logic [NIN-1:0]    raw, syn, prev_q;
  logic              sck_rise, stb_rise, div_fall, addr_ok, load, trig;
  logic [WORD_W-1:0] word;
  ctrl_fields_t      fields;

  assign raw = {div_out_i, ser_strobe_i, ser_data_i, ser_clk_i};

  cwl_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= syn;

  assign sck_rise = syn[I_SCK] & ~prev_q[I_SCK];
  assign stb_rise = syn[I_STB] & ~prev_q[I_STB];
  assign div_fall = ~syn[I_DIV] & prev_q[I_DIV];

  cwl_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sck_rise),
    .bit_i(syn[I_SDA]), .word_o(word));

  assign addr_ok = (word[ADDR_LSB +: ADDR_W] == ADDR_MATCH);
  assign load    = stb_rise & addr_ok;
  assign trig    = load & word[EN_BIT];

  cwl_fields u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .word_i(word), .fields_o(fields));

  cwl_rst_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .fall_i(div_fall), .mod_rst_o(mod_rst_o));

  assign div_val_o    = fields.div;
  assign cp_ratio_o   = fields.cp;
  assign lock_mode_o  = fields.ld;
  assign mod_rst_en_o = fields.rst_en;
  assign cmp_sel_o    = fields.sel;

  assert_no_rst_without_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_o) |-> !mod_rst_en_o || $past(div_fall));
endmodule

// File: tb/ctrl_word_loader_tb.sv
module ctrl_word_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sda = 1'b0, stb = 1'b0, dvo = 1'b1;
  logic [13:0] div_val;
  logic [1:0]  cp_ratio, lock_mode;
  logic        rst_en, mod_rst;
  logic [2:0]  cmp_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ctrl_word_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_data_i(sda),
    .ser_strobe_i(stb), .div_out_i(dvo), .div_val_o(div_val), .cp_ratio_o(cp_ratio),
    .lock_mode_o(lock_mode), .mod_rst_en_o(rst_en), .cmp_sel_o(cmp_sel), .mod_rst_o(mod_rst));

  // reference model: inputs act three edges after they are sampled
  logic [3:0]  hist [$];
  logic [23:0] m_sr;
  logic [21:0] m_fld;
  int          m_state;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {4'b0, 4'b0, 4'b0, 4'b0};
      m_sr = '0; m_fld = '0; m_state = 0;
    end else begin
      logic [3:0] a, b;
      hist.push_back({dvo, stb, sda, sck});
      a = hist[hist.size()-3];
      b = hist[hist.size()-4];
      if (a[2] && !b[2] && m_sr[23:22] == 2'b10) begin
        m_fld = m_sr[21:0];
        if (m_sr[3]) m_state = 1;
        else if (!a[3] && b[3]) m_state = (m_state == 1) ? 2 : 0;
      end else if (!a[3] && b[3]) begin
        if (m_state == 1) m_state = 2;
        else if (m_state == 2) m_state = 0;
      end
      if (a[0] && !b[0]) m_sr = {m_sr[22:0], a[1]};
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3/R4 fields vs model", {10'b0, div_val, cp_ratio, lock_mode, rst_en, cmp_sel},
          {10'b0, m_fld});
      chk("R6 mod_rst vs model", {31'b0, mod_rst}, {31'b0, (m_state == 2)});
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sda = w[i]; sck = 1'b0;
      wait_cyc(4); sck = 1'b1;
      wait_cyc(4); sck = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk); stb = 1'b1;
    wait_cyc(4); stb = 1'b0;
    wait_cyc(4);
  endtask

  task automatic div_edge();
    @(negedge clk); dvo = 1'b0;
    wait_cyc(6); dvo = 1'b1;
    wait_cyc(6);
  endtask

  function automatic logic [23:0] mk(input logic [1:0] ad, input logic [13:0] dv,
                                     input logic [1:0] cp, input logic [1:0] ld,
                                     input logic en, input logic [2:0] sl);
    return {ad, dv, cp, ld, en, sl};
  endfunction

  task automatic chk_fields(input string req, input logic [23:0] w);
    chk({req, " div"}, {18'b0, div_val}, {18'b0, w[21:8]});
    chk({req, " cp"},  {30'b0, cp_ratio}, {30'b0, w[7:6]});
    chk({req, " ld"},  {30'b0, lock_mode}, {30'b0, w[5:4]});
    chk({req, " en"},  {31'b0, rst_en}, {31'b0, w[3]});
    chk({req, " sel"}, {29'b0, cmp_sel}, {29'b0, w[2:0]});
  endtask

  initial begin
    logic [23:0] w1, w2, w3, w4;
    w1 = mk(2'b10, 14'h1A5C, 2'b01, 2'b10, 1'b0, 3'b101);
    w2 = mk(2'b01, 14'h3FFF, 2'b11, 2'b11, 1'b1, 3'b111);
    w3 = mk(2'b10, 14'h0123, 2'b10, 2'b01, 1'b1, 3'b011);
    w4 = mk(2'b10, 14'h2222, 2'b00, 2'b11, 1'b1, 3'b100);

    wait_cyc(5);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(4);
    chk_fields("R1 reset", 24'h0);
    chk("R1 mod_rst", {31'b0, mod_rst}, 32'h0);

    // R3 load, R7 enable clear
    shift_bits({8'b0, w1}, 24);
    strobe();
    chk_fields("R3 load", w1);
    div_edge(); div_edge(); div_edge();
    chk("R7 no reset", {31'b0, mod_rst}, 32'h0);

    // R4 other address ignored
    shift_bits({8'b0, w2}, 24);
    strobe();
    chk_fields("R4 wrong addr", w1);

    // R2 overlong burst: only last 24 bits count
    shift_bits({6'b0, 2'b11, 24'b0} | {8'b0, w3}, 26);
    shift_bits({8'b0, w3}, 24);
    strobe();
    chk_fields("R2 last 24", w3);

    // R6 window
    chk("R6 idle before edge", {31'b0, mod_rst}, 32'h0);
    div_edge();
    chk("R6 high after 1st fall", {31'b0, mod_rst}, 32'h1);
    div_edge();
    chk("R6 low after 2nd fall", {31'b0, mod_rst}, 32'h0);
    div_edge();
    chk("R6 stays low", {31'b0, mod_rst}, 32'h0);

    // R5 shifting alone changes nothing
    shift_bits(32'h3FF, 10);
    wait_cyc(4);
    chk_fields("R5 shift no strobe", w3);

    // R8 restart during window
    shift_bits({8'b0, w3}, 24);
    strobe();
    div_edge();
    chk("R8 high before restart", {31'b0, mod_rst}, 32'h1);
    shift_bits({8'b0, w4}, 24);
    strobe();
    chk("R8 dropped on restart", {31'b0, mod_rst}, 32'h0);
    chk_fields("R8 fields", w4);
    div_edge();
    chk("R8 high after new 1st fall", {31'b0, mod_rst}, 32'h1);
    div_edge();
    chk("R8 low after new 2nd fall", {31'b0, mod_rst}, 32'h0);

    wait_cyc(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule